// File: doc/BRIEF.md
# Variable-Width CPU Register File

This block holds the programmer-visible registers of an 8/16-bit accumulator CPU core: a two-byte accumulator (a visible low byte plus a high byte that stays stored when the accumulator is narrow), two index registers, a stack pointer, a direct-page base, and the data and program bank bytes. A mode flag selects emulation or native operation. Two width flags set the width of the accumulator and of the index pair. In emulation mode both widths are forced to 8 bits.

The surrounding core changes the flags through a flag port. It writes registers through a load port or a register-to-register transfer port, and it can swap the two accumulator bytes. One read port returns a register's visible value together with the number of bytes that register takes on the stack. The two kinds of register react differently when their width narrows. The index high bytes are destroyed. The accumulator high byte is kept and shows again when the accumulator widens.

Register codes are used on every select port: 0 accumulator, 1 index X, 2 index Y, 3 stack pointer, 4 direct base, 5 data bank, 6 program bank, 7 width-flag byte.

Top module: `cpu_regbank`

## Requirements
- R1: After reset the block is in emulation mode with both width flags set. The stack pointer reads 0x01FF. The direct base, both bank bytes, the accumulator and both index registers read zero.
- R2: In emulation mode the accumulator and index registers act as 8 bits, whatever values the width flags were given. The effective widths show on `acc_narrow` and `idx_narrow`, where 1 means 8 bits.
- R3: When the index width narrows, the high bytes of X and Y become zero. When it widens again they stay zero, so the old high bytes cannot be recovered.
- R4: With an 8-bit accumulator, reading code 0 returns the high byte as zero while the stored high byte is kept. When the accumulator widens, the stored high byte shows again.
- R5: A swap request exchanges the accumulator low byte and the stored high byte. Both values are kept; neither is copied over the other.
- R6: A transfer out of the accumulator carries all 16 bits, whatever the accumulator width. A load or transfer into an 8-bit accumulator writes only the low byte and leaves the stored high byte unchanged.
- R7: A load or transfer into an 8-bit index register writes the low byte and clears the high byte. A transfer out of an 8-bit index register therefore carries a zero high byte.
- R8: `rd_bytes` gives the stack size of the selected register. Codes 0 and 1/2 give 1 when their width is 8 bits and 2 when it is 16 bits. Codes 3 and 4 always give 2. Codes 5, 6 and 7 always give 1.
- R9: The stack pointer and the direct base hold 16 bits. The bank bytes hold 8 bits and read with a zero high byte. Code 7 reads {14 zero bits, acc_narrow, idx_narrow}.
- R10: When a register write and a flag update fall in the same cycle, the write uses the widths in force before that cycle. A narrowing of the index width is then applied to the written result. When several requests arrive together, a transfer wins over a load, and a load wins over a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_we | input | 1 | Update the mode and width flags |
| emu_in | input | 1 | New mode flag (1 = emulation) |
| m_in | input | 1 | New accumulator width flag (1 = 8 bits) |
| x_in | input | 1 | New index width flag (1 = 8 bits) |
| ld_en | input | 1 | Load request |
| ld_sel | input | 3 | Register code to load |
| ld_data | input | 16 | Load value |
| xfer_en | input | 1 | Transfer request |
| xfer_src | input | 3 | Transfer source code |
| xfer_dst | input | 3 | Transfer destination code |
| swap_ab | input | 1 | Exchange the accumulator low byte and the stored high byte |
| rd_sel | input | 3 | Read register code |
| rd_data | output | 16 | Visible value of the selected register |
| rd_bytes | output | 2 | Stack byte count of the selected register |
| emu | output | 1 | Emulation mode active |
| acc_narrow | output | 1 | Effective accumulator width is 8 bits |
| idx_narrow | output | 1 | Effective index width is 8 bits |

## Verification
The interesting collision is a width-flag update in the same cycle as a register write. The bench drives a 16-bit index load in the very cycle that narrows the index width, and expects only the low byte to survive. It also drives a load while the index width is 8 bits, in the cycle that widens it, and expects the write to follow the old 8-bit width. A second collision sets a transfer and a load to the accumulator in the same cycle, and the transfer value must win.

// File: rtl/cpu_regbank.sv
module cpu_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flag_we,
  input  logic        emu_in,
  input  logic        m_in,
  input  logic        x_in,
  input  logic        ld_en,
  input  logic [2:0]  ld_sel,
  input  logic [15:0] ld_data,
  input  logic        xfer_en,
  input  logic [2:0]  xfer_src,
  input  logic [2:0]  xfer_dst,
  input  logic        swap_ab,
  input  logic [2:0]  rd_sel,
  output logic [15:0] rd_data,
  output logic [1:0]  rd_bytes,
  output logic        emu,
  output logic        acc_narrow,
  output logic        idx_narrow
);
  localparam logic [2:0] SEL_ACC = 3'd0, SEL_IX = 3'd1, SEL_IY = 3'd2, SEL_SP = 3'd3,
                         SEL_DP = 3'd4, SEL_DB = 3'd5, SEL_PB = 3'd6;
  localparam logic [15:0] SP_RESET = 16'h01FF;

  logic [7:0]  acc_lo, acc_hi, dbank, pbank;
  logic [15:0] ix_r, iy_r, sp_r, dp_r;
  logic        emu_r, mflag, xflag;

  assign emu        = emu_r;
  assign acc_narrow = emu_r | mflag;
  assign idx_narrow = emu_r | xflag;

  function automatic logic [15:0] full_val(input logic [2:0] s);
    case (s)
      SEL_ACC: full_val = {acc_hi, acc_lo};
      SEL_IX:  full_val = ix_r;
      SEL_IY:  full_val = iy_r;
      SEL_SP:  full_val = sp_r;
      SEL_DP:  full_val = dp_r;
      SEL_DB:  full_val = {8'h00, dbank};
      SEL_PB:  full_val = {8'h00, pbank};
      default: full_val = {14'b0, acc_narrow, idx_narrow};
    endcase
  endfunction

  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_val, idx_val, ix_wr, iy_wr, ix_nx, iy_nx;
  logic        idx_narrow_nx;

  assign wr_en   = xfer_en | ld_en;
  assign wr_sel  = xfer_en ? xfer_dst : ld_sel;
  assign wr_val  = xfer_en ? full_val(xfer_src) : ld_data;
  assign idx_val = idx_narrow ? {8'h00, wr_val[7:0]} : wr_val;
  assign ix_wr   = (wr_en && wr_sel == SEL_IX) ? idx_val : ix_r;
  assign iy_wr   = (wr_en && wr_sel == SEL_IY) ? idx_val : iy_r;
  assign idx_narrow_nx = flag_we ? (emu_in | x_in) : idx_narrow;
  assign ix_nx   = idx_narrow_nx ? {8'h00, ix_wr[7:0]} : ix_wr;
  assign iy_nx   = idx_narrow_nx ? {8'h00, iy_wr[7:0]} : iy_wr;

  always_comb begin
    rd_data = full_val(rd_sel);
    if (rd_sel == SEL_ACC && acc_narrow) rd_data = {8'h00, acc_lo};
    case (rd_sel)
      SEL_ACC:       rd_bytes = acc_narrow ? 2'd1 : 2'd2;
      SEL_IX, SEL_IY: rd_bytes = idx_narrow ? 2'd1 : 2'd2;
      SEL_SP, SEL_DP: rd_bytes = 2'd2;
      default:       rd_bytes = 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emu_r <= 1'b1; mflag <= 1'b1; xflag <= 1'b1;
      acc_lo <= '0; acc_hi <= '0; ix_r <= '0; iy_r <= '0;
      sp_r <= SP_RESET; dp_r <= '0; dbank <= '0; pbank <= '0;
    end else begin
      if (flag_we) begin
        emu_r <= emu_in; mflag <= m_in; xflag <= x_in;
      end
      ix_r <= ix_nx;
      iy_r <= iy_nx;
      if (wr_en) begin
        case (wr_sel)
          SEL_ACC: begin
            acc_lo <= wr_val[7:0];
            if (!acc_narrow) acc_hi <= wr_val[15:8];
          end
          SEL_SP:  sp_r  <= wr_val;
          SEL_DP:  dp_r  <= wr_val;
          SEL_DB:  dbank <= wr_val[7:0];
          SEL_PB:  pbank <= wr_val[7:0];
          default: ;
        endcase
      end else if (swap_ab) begin
        acc_lo <= acc_hi;
        acc_hi <= acc_lo;
      end
    end
  end
endmodule

module cpu_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        emu,
  input logic        idx_narrow,
  input logic        swap_ab,
  input logic        ld_en,
  input logic        xfer_en,
  input logic [2:0]  ld_sel,
  input logic [2:0]  xfer_dst,
  input logic [2:0]  rd_sel,
  input logic [1:0]  rd_bytes,
  input logic [15:0] ix_r,
  input logic [15:0] iy_r,
  input logic [7:0]  acc_lo,
  input logic [7:0]  acc_hi
);
  assert_idx_high_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_narrow |-> (ix_r[15:8] == 8'h00 && iy_r[15:8] == 8'h00));

  assert_hidden_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_ab && !(ld_en && ld_sel == 3'd0) && !(xfer_en && xfer_dst == 3'd0)) |=> $stable(acc_hi));

  assert_swap_exchange_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_ab && !ld_en && !xfer_en) |=> (acc_lo == $past(acc_hi) && acc_hi == $past(acc_lo)));

  assert_emu_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (emu && rd_sel == 3'd0) |-> rd_bytes == 2'd1);

  assert_fixed_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd3 || rd_sel == 3'd4) |-> rd_bytes == 2'd2);
endmodule

bind cpu_regbank cpu_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .emu(emu), .idx_narrow(idx_narrow), .swap_ab(swap_ab),
  .ld_en(ld_en), .xfer_en(xfer_en), .ld_sel(ld_sel), .xfer_dst(xfer_dst),
  .rd_sel(rd_sel), .rd_bytes(rd_bytes), .ix_r(ix_r), .iy_r(iy_r),
  .acc_lo(acc_lo), .acc_hi(acc_hi)
);

// File: tb/sim_cpu_regbank.sv
module sim_cpu_regbank;
  logic clk = 0, rst_n = 0;
  logic flag_we = 0, emu_in = 0, m_in = 0, x_in = 0;
  logic ld_en = 0, xfer_en = 0, swap_ab = 0;
  logic [2:0] ld_sel = 0, xfer_src = 0, xfer_dst = 0, rd_sel = 0;
  logic [15:0] ld_data = 0;
  logic [15:0] rd_data;
  logic [1:0] rd_bytes;
  logic emu, acc_narrow, idx_narrow;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  cpu_regbank u0 (.*);

  task automatic chk(input [2:0] sel, input [15:0] exp_d, input [1:0] exp_b, input string req);
    rd_sel = sel; #1;
    runs++;
    if (rd_data !== exp_d || rd_bytes !== exp_b) begin
      fails++;
      $display("FAIL %s sel=%0d data=%h bytes=%0d expected data=%h bytes=%0d", req, sel, rd_data, rd_bytes, exp_d, exp_b);
    end
  endtask

  task automatic idle;
    flag_we = 0; ld_en = 0; xfer_en = 0; swap_ab = 0;
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic flags(input e, input m, input x);
    flag_we = 1; emu_in = e; m_in = m; x_in = x; step();
  endtask

  task automatic load(input [2:0] s, input [15:0] v);
    ld_en = 1; ld_sel = s; ld_data = v; step();
  endtask

  task automatic xfer(input [2:0] s, input [2:0] d);
    xfer_en = 1; xfer_src = s; xfer_dst = d; step();
  endtask

  task automatic t_reset;
    chk(0, 16'h0000, 1, "R1"); chk(1, 16'h0000, 1, "R1");
    chk(3, 16'h01FF, 2, "R1"); chk(4, 16'h0000, 2, "R1");
    chk(5, 16'h0000, 1, "R1"); chk(6, 16'h0000, 1, "R1");
    runs++; if (!(emu && acc_narrow && idx_narrow)) begin fails++; $display("FAIL R1 flags=%b%b%b expected 111", emu, acc_narrow, idx_narrow); end
  endtask

  task automatic t_emu;
    flags(1, 0, 0);
    chk(0, 16'h0000, 1, "R2"); chk(7, 16'h0003, 1, "R2");
    flags(0, 0, 0);
    chk(0, 16'h0000, 2, "R2"); chk(7, 16'h0000, 1, "R2");
  endtask

  task automatic t_acc_cycle;
    load(0, 16'h1234);
    chk(0, 16'h1234, 2, "R4");
    flags(0, 1, 0); chk(0, 16'h0034, 1, "R4");
    flags(0, 0, 0); chk(0, 16'h1234, 2, "R4");
  endtask

  task automatic t_idx_cycle;
    load(1, 16'hABCD); load(2, 16'h4321);
    chk(1, 16'hABCD, 2, "R3");
    flags(0, 0, 1); chk(1, 16'h00CD, 1, "R3"); chk(2, 16'h0021, 1, "R3");
    flags(0, 0, 0); chk(1, 16'h00CD, 2, "R3"); chk(2, 16'h0021, 2, "R3");
  endtask

  task automatic t_swap;
    flags(0, 1, 0);
    swap_ab = 1; step();
    chk(0, 16'h0012, 1, "R5");
    flags(0, 0, 0); chk(0, 16'h3412, 2, "R5");
  endtask

  task automatic t_acc_xfer;
    flags(0, 1, 0);
    xfer(0, 1); chk(1, 16'h3412, 2, "R6");
    xfer(0, 4); chk(4, 16'h3412, 2, "R6");
    load(1, 16'h5678); xfer(1, 0);
    chk(0, 16'h0078, 1, "R6");
    flags(0, 0, 0); chk(0, 16'h3478, 2, "R6");
    flags(0, 1, 0); load(0, 16'hFF11);
    flags(0, 0, 0); chk(0, 16'h3411, 2, "R6");
  endtask

  task automatic t_idx_narrow_moves;
    flags(0, 0, 1);
    load(1, 16'hFFEE); chk(1, 16'h00EE, 1, "R7");
    xfer(1, 4); chk(4, 16'h00EE, 2, "R7");
    xfer(3, 2); chk(2, 16'h00FF, 1, "R7");
  endtask

  task automatic t_wide_regs;
    load(3, 16'hBEEF); chk(3, 16'hBEEF, 2, "R9");
    load(4, 16'h8001); chk(4, 16'h8001, 2, "R9");
    load(5, 16'h1299); chk(5, 16'h0099, 1, "R9");
    load(6, 16'h77A5); chk(6, 16'h00A5, 1, "R9");
    chk(7, 16'h0001, 1, "R8");
  endtask

  task automatic t_collide;
    flags(0, 0, 0);
    ld_en = 1; ld_sel = 1; ld_data = 16'hBEEF;
    flag_we = 1; emu_in = 0; m_in = 0; x_in = 1; step();
    chk(1, 16'h00EF, 1, "R10");
    ld_en = 1; ld_sel = 2; ld_data = 16'hCAFE;
    flag_we = 1; emu_in = 0; m_in = 0; x_in = 0; step();
    chk(2, 16'h00FE, 2, "R10");
    load(4, 16'h5AA5);
    xfer_en = 1; xfer_src = 4; xfer_dst = 0; ld_en = 1; ld_sel = 0; ld_data = 16'h1111;
    swap_ab = 1; step();
    chk(0, 16'h5AA5, 2, "R10");
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_emu();
    t_acc_cycle();
    t_idx_cycle();
    t_swap();
    t_acc_xfer();
    t_idx_narrow_moves();
    t_wide_regs();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule